// File: doc/BRIEF.md
# Cell Overcharge Delay Controller

This block is the digital decision core of a secondary overcharge guard for a battery pack of two or three cells in series. For each cell it receives two comparator results: one says the cell is above its overcharge threshold, and the other says the cell is below its release level, which is the threshold minus the hysteresis. It filters these results in time with tick-driven counters and drives a charge-control pin. That pin switches the external charge FET off while the pack is in overcharge.

The overcharge decision waits for a persistence delay chosen from three multi-second presets. A latched test mode shortens this delay to a few tens of milliseconds for production screening. An entry request held for a qualification window sets the latch, and the first overcharge detection clears it. The pin polarity and the drive style are selectable. The drive style is either push-pull or open-drain, where open-drain means the pin is pulled low or released through an output enable. All configuration is captured while reset is asserted.

Top module: `ovc_guard`

## Requirements
- R1: When any enabled cell's over flag is high on each of N consecutive ticks, where N is the active detection delay, the block enters overcharge on the Nth such tick and stays in normal status before it.
- R2: A cycle in which no enabled over flag is high restarts the detection count from zero.
- R3: In overcharge, the block returns to normal status on the 2nd consecutive tick at which every enabled cell's under flag is high. A cycle in which any enabled under flag is low restarts that count.
- R4: The detection delay is set by cfg_dly_sel: value 0 gives 2000 ticks, value 1 gives 4000 ticks, and values 2 and 3 give 8000 ticks.
- R5: A test request held high for 20 consecutive ticks sets the test latch, which stays set after the request drops. A drop before the 20th tick restarts the count, and no latch is set.
- R6: While the test latch is set, the detection delay is 32 ticks.
- R7: Entering overcharge clears the test latch, so the next detection uses the preset delay again.
- R8: The pin level is high in overcharge when cfg_act_low=0 and low in overcharge when cfg_act_low=1, and the opposite level applies in normal status. In push-pull mode (cfg_open_drain=0), chg_ctl_oe=1 and chg_ctl_out carries the level. In open-drain mode, chg_ctl_out=0 and chg_ctl_oe=1 only when the level is low.
- R9: With cfg_two_cell=1, the flags of the third cell (bit 2) are ignored: its over flag never counts, and its under flag is taken as high.
- R10: After reset the block is in normal status with the test latch clear and all counts at zero.
- R11: Changes on the configuration inputs after reset has been released have no effect until the next reset.
- R12: Counts advance only in cycles where tick_1k is high, so without ticks the status never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| tick_1k | input | 1 | Timing enable, one cycle high per millisecond |
| cell_over | input | NCELL | Per cell: the cell is above its overcharge threshold |
| cell_under | input | NCELL | Per cell: the cell is below its release level |
| test_req | input | 1 | Test-entry condition from the supply-offset comparator |
| cfg_dly_sel | input | 2 | Detection delay preset, captured during reset |
| cfg_act_low | input | 1 | 1 = pin is low in overcharge, captured during reset |
| cfg_open_drain | input | 1 | 1 = open-drain drive, captured during reset |
| cfg_two_cell | input | 1 | 1 = only two cells are fitted, captured during reset |
| chg_ctl_out | output | 1 | Charge-control pin data |
| chg_ctl_oe | output | 1 | Charge-control pin drive enable |

## Verification
A wrong internal state shows at the pin as a transition on the wrong tick. A detection counter that is stuck or misloaded moves the overcharge edge away from tick 2000, 4000, 8000 or 32, so the per-cycle reference comparison flags the error at that edge. A test latch that is lost or left set shows up only at the next detection, as a delay of the wrong length. A wrong release count shows within two ticks of the cells dropping, and a polarity or drive error shows at once in the reset state.

// File: rtl/ovc_pkg.sv
package ovc_pkg;

  typedef enum logic {
    ST_NORMAL = 1'b0,
    ST_OVC    = 1'b1
  } ovc_state_e;

  typedef struct packed {
    logic [1:0] dly_sel;
    logic       act_low;
    logic       open_drain;
    logic       two_cell;
  } ovc_cfg_t;

endpackage

// File: rtl/ovc_rst_sync.sv
module ovc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/ovc_cell_mask.sv
module ovc_cell_mask #(
  parameter int NCELL = 3
) (
  input  logic             two_cell,
  input  logic [NCELL-1:0] over_in,
  input  logic [NCELL-1:0] under_in,
  output logic             any_over,
  output logic             all_under
);
  logic [NCELL-1:0] over_m;
  logic [NCELL-1:0] under_m;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    if (i == NCELL - 1) begin : g_top
      // the highest cell drops out in reduced-count packs
      assign over_m[i]  = over_in[i]  & ~two_cell;
      assign under_m[i] = under_in[i] |  two_cell;
    end else begin : g_fixed
      assign over_m[i]  = over_in[i];
      assign under_m[i] = under_in[i];
    end
  end

  assign any_over  = |over_m;
  assign all_under = &under_m;
endmodule

// File: rtl/ovc_tick_timer.sv
module ovc_tick_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         fire
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign fire = run & tick & ~clr & (cnt_q >= (limit - W'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !run)  cnt_d = '0;
    else if (tick)    cnt_d = fire ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ovc_guard.sv
module ovc_guard
  import ovc_pkg::*;
#(
  parameter int NCELL      = 3,
  parameter int DLY_T0     = 2000,
  parameter int DLY_T1     = 4000,
  parameter int DLY_T2     = 8000,
  parameter int TEST_DLY   = 32,
  parameter int REL_DLY    = 2,
  parameter int ENTRY_DLY  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1k,
  input  logic [NCELL-1:0] cell_over,
  input  logic [NCELL-1:0] cell_under,
  input  logic             test_req,
  input  logic [1:0]       cfg_dly_sel,
  input  logic             cfg_act_low,
  input  logic             cfg_open_drain,
  input  logic             cfg_two_cell,
  output logic             chg_ctl_out,
  output logic             chg_ctl_oe
);
  localparam int MAXD  = (DLY_T2 > DLY_T1) ? ((DLY_T2 > DLY_T0) ? DLY_T2 : DLY_T0)
                                           : ((DLY_T1 > DLY_T0) ? DLY_T1 : DLY_T0);
  localparam int CNT_W = $clog2(MAXD + 1);

  logic       rst_sn;
  ovc_cfg_t   cfg_q;
  ovc_state_e state_q, state_d;
  logic       test_q, test_d;
  logic       ovc_q;
  logic       any_over, all_under;
  logic       det_fire, rel_fire, ent_fire;
  logic [CNT_W-1:0] det_limit;
  logic       pin_level;
  logic       od_sel;

  ovc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  // configuration follows the pins only while reset is held
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cfg_q.dly_sel    <= cfg_dly_sel;
      cfg_q.act_low    <= cfg_act_low;
      cfg_q.open_drain <= cfg_open_drain;
      cfg_q.two_cell   <= cfg_two_cell;
    end
  end

  ovc_cell_mask #(.NCELL(NCELL)) u_mask (
    .two_cell  (cfg_q.two_cell),
    .over_in   (cell_over),
    .under_in  (cell_under),
    .any_over  (any_over),
    .all_under (all_under)
  );

  assign ovc_q = (state_q == ST_OVC);

  always_comb begin
    if (test_q) det_limit = CNT_W'(TEST_DLY);
    else begin
      unique case (cfg_q.dly_sel)
        2'd0:    det_limit = CNT_W'(DLY_T0);
        2'd1:    det_limit = CNT_W'(DLY_T1);
        default: det_limit = CNT_W'(DLY_T2);
      endcase
    end
  end

  ovc_tick_timer #(.W(CNT_W)) u_det (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (ovc_q),
    .run   (any_over),
    .tick  (tick_1k),
    .limit (det_limit),
    .fire  (det_fire)
  );

  ovc_tick_timer #(.W(CNT_W)) u_rel (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (~ovc_q),
    .run   (all_under),
    .tick  (tick_1k),
    .limit (CNT_W'(REL_DLY)),
    .fire  (rel_fire)
  );

  ovc_tick_timer #(.W(CNT_W)) u_ent (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (det_fire),
    .run   (test_req),
    .tick  (tick_1k),
    .limit (CNT_W'(ENTRY_DLY)),
    .fire  (ent_fire)
  );

  always_comb begin
    state_d = state_q;
    test_d  = test_q;
    if (det_fire) begin
      state_d = ST_OVC;
      test_d  = 1'b0;
    end else begin
      if (rel_fire) state_d = ST_NORMAL;
      if (ent_fire) test_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_NORMAL;
      test_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      test_q  <= test_d;
    end
  end

  assign od_sel    = cfg_q.open_drain;
  assign pin_level = ovc_q ^ cfg_q.act_low;

  always_comb begin
    if (od_sel) begin
      chg_ctl_out = 1'b0;
      chg_ctl_oe  = ~pin_level;
    end else begin
      chg_ctl_out = pin_level;
      chg_ctl_oe  = 1'b1;
    end
  end
endmodule

// File: rtl/ovc_guard_chk.sv
module ovc_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic ovc_q,
  input logic test_q,
  input logic any_over,
  input logic all_under,
  input logic ctl_out,
  input logic ctl_oe,
  input logic od_sel
);
  a_r1_rise_needs_over: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovc_q) |-> $past(any_over && tick));

  a_r3_fall_needs_under: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovc_q) |-> $past(all_under && tick));

  a_r7_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovc_q) |-> !test_q);

  a_r5_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_q) |-> $rose(ovc_q));

  a_r12_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(ovc_q) && !$rose(test_q)));

  a_r8_push_pull_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !od_sel |-> ctl_oe);

  a_r8_open_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
    od_sel |-> !ctl_out);
endmodule

bind ovc_guard ovc_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .tick      (tick_1k),
  .ovc_q     (ovc_q),
  .test_q    (test_q),
  .any_over  (any_over),
  .all_under (all_under),
  .ctl_out   (chg_ctl_out),
  .ctl_oe    (chg_ctl_oe),
  .od_sel    (od_sel)
);

// File: tb/ovc_guard_test.sv
`timescale 1ns/1ps
module ovc_guard_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1k;
  logic [2:0] cell_over, cell_under;
  logic       test_req;
  logic [1:0] cfg_dly_sel;
  logic       cfg_act_low, cfg_open_drain, cfg_two_cell;
  logic       chg_ctl_out, chg_ctl_oe;

  int n_vec  = 0;
  int n_fail = 0;
  string cur_tag = "R10";

  always #10 clk = ~clk;

  ovc_guard uut (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k),
    .cell_over(cell_over), .cell_under(cell_under), .test_req(test_req),
    .cfg_dly_sel(cfg_dly_sel), .cfg_act_low(cfg_act_low),
    .cfg_open_drain(cfg_open_drain), .cfg_two_cell(cfg_two_cell),
    .chg_ctl_out(chg_ctl_out), .chg_ctl_oe(chg_ctl_oe)
  );

  // behavioural reference
  int m_ovc, m_tm, m_det, m_rel, m_ent;
  int m_sel, m_al, m_od, m_two;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ovc = 0; m_tm = 0; m_det = 0; m_rel = 0; m_ent = 0;
      m_sel = cfg_dly_sel; m_al = cfg_act_low; m_od = cfg_open_drain; m_two = cfg_two_cell;
    end else begin
      int lim, anyo, allu, fd, fr, fe;
      lim  = m_tm ? 32 : (m_sel == 0 ? 2000 : (m_sel == 1 ? 4000 : 8000));
      anyo = 0; allu = 1;
      for (int i = 0; i < 3; i++) begin
        bit en;
        en = !(m_two && i == 2);
        if (en && cell_over[i]) anyo = 1;
        if (en && !cell_under[i]) allu = 0;
      end
      fd = (!m_ovc && anyo && tick_1k && (m_det + 1 >= lim));
      fr = (m_ovc && allu && tick_1k && (m_rel + 1 >= 2));
      fe = (!fd && test_req && tick_1k && (m_ent + 1 >= 20));
      if (m_ovc || !anyo) m_det = 0; else if (tick_1k) m_det = fd ? 0 : m_det + 1;
      if (!m_ovc || !allu) m_rel = 0; else if (tick_1k) m_rel = fr ? 0 : m_rel + 1;
      if (!test_req || fd) m_ent = 0; else if (tick_1k) m_ent = fe ? 0 : m_ent + 1;
      if (fd) begin m_ovc = 1; m_tm = 0; end
      else begin
        if (fr) m_ovc = 0;
        if (fe) m_tm = 1;
      end
    end
  end

  function automatic logic [1:0] exp_pins(int ovc);
    logic lvl;
    lvl = logic'(ovc) ^ logic'(m_al);
    if (m_od != 0) return {1'b0, ~lvl};
    return {lvl, 1'b1};
  endfunction

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] e;
      e = exp_pins(m_ovc);
      n_vec++;
      if ({chg_ctl_out, chg_ctl_oe} !== e) begin
        n_fail++;
        $display("FAIL %s model: out/oe=%b%b expected %b%b at %0t",
                 cur_tag, chg_ctl_out, chg_ctl_oe, e[1], e[0], $time);
      end
    end
  end

  task automatic adv(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ovc(int e, string tag);
    logic [1:0] p;
    p = exp_pins(e);
    n_vec++;
    if ({chg_ctl_out, chg_ctl_oe} !== p) begin
      n_fail++;
      $display("FAIL %s: out/oe=%b%b expected %b%b at %0t",
               tag, chg_ctl_out, chg_ctl_oe, p[1], p[0], $time);
    end
  endtask

  task automatic set_idle();
    cell_over = 3'b000; cell_under = 3'b111;
  endtask

  task automatic set_over(logic [2:0] m);
    cell_over = m; cell_under = ~m;
  endtask

  task automatic do_reset(logic [1:0] sel, logic al, logic od, logic two);
    rst_n = 1'b0; tick_1k = 1'b0; test_req = 1'b0; set_idle();
    cfg_dly_sel = sel; cfg_act_low = al; cfg_open_drain = od; cfg_two_cell = two;
    adv(3);
    rst_n = 1'b1;
    adv(4);
    tick_1k = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; tick_1k = 1'b0; test_req = 1'b0;
    cell_over = '0; cell_under = '1;
    cfg_dly_sel = '0; cfg_act_low = 1'b0; cfg_open_drain = 1'b0; cfg_two_cell = 1'b0;

    // push-pull, active high, 3 cells, 2000-tick preset
    do_reset(2'd0, 1'b0, 1'b0, 1'b0);
    cur_tag = "R10"; expect_ovc(0, "R10 reset state");
    cur_tag = "R5"; test_req = 1'b1; adv(19); test_req = 1'b0; adv(2);
    cur_tag = "R1"; set_over(3'b010); adv(1999); expect_ovc(0, "R1 before delay");
    adv(1); expect_ovc(1, "R1 at delay (R5 short request not latched)");
    cur_tag = "R3"; cell_over = 3'b000; cell_under = 3'b011; adv(10);
    expect_ovc(1, "R3 one cell not under");
    cell_under = 3'b111; adv(1); expect_ovc(1, "R3 first tick");
    adv(1); expect_ovc(0, "R3 second tick");
    cur_tag = "R2"; set_over(3'b001); adv(1500); set_idle(); adv(1);
    set_over(3'b001); adv(1999); expect_ovc(0, "R2 restarted count");
    adv(1); expect_ovc(1, "R2 full delay after restart");
    set_idle(); adv(3);
    cur_tag = "R12"; tick_1k = 1'b0; set_over(3'b100); adv(3000);
    expect_ovc(0, "R12 no ticks");
    tick_1k = 1'b1; adv(1999); expect_ovc(0, "R12 ticks resumed");
    adv(1); expect_ovc(1, "R12 detection after ticks");
    set_idle(); adv(3);
    cur_tag = "R6"; test_req = 1'b1; adv(20); test_req = 1'b0; adv(5);
    set_over(3'b001); adv(31); expect_ovc(0, "R6 before test delay");
    adv(1); expect_ovc(1, "R6 test delay");
    set_idle(); adv(3);
    cur_tag = "R7"; set_over(3'b001); adv(1999); expect_ovc(0, "R7 latch cleared");
    adv(1); expect_ovc(1, "R7 preset delay");
    cur_tag = "R11"; cfg_act_low = 1'b1; cfg_open_drain = 1'b1; cfg_dly_sel = 2'd2; adv(3);
    expect_ovc(1, "R11 config ignored after reset");
    set_idle(); adv(3); expect_ovc(0, "R11 release with old config");

    // open-drain, active low, 4000-tick preset
    do_reset(2'd1, 1'b1, 1'b1, 1'b0);
    cur_tag = "R8"; expect_ovc(0, "R8 od active-low normal released");
    cur_tag = "R4"; set_over(3'b100); adv(3999); expect_ovc(0, "R4 sel1 before");
    adv(1); expect_ovc(1, "R8 od active-low pulled low");
    set_idle(); adv(3);

    // open-drain, active high, two cells, 8000-tick preset
    do_reset(2'd2, 1'b0, 1'b1, 1'b1);
    cur_tag = "R9"; expect_ovc(0, "R8 od active-high normal pulled low");
    cell_over = 3'b100; cell_under = 3'b011; adv(8100);
    expect_ovc(0, "R9 third cell over ignored");
    cur_tag = "R4"; cell_over = 3'b001; cell_under = 3'b110; adv(7999);
    expect_ovc(0, "R4 sel2 before");
    adv(1); expect_ovc(1, "R9 two-cell detection");
    cur_tag = "R9"; cell_over = 3'b000; cell_under = 3'b011; adv(2);
    expect_ovc(0, "R9 third cell under ignored on release");

    // push-pull, active low, preset code 3
    do_reset(2'd3, 1'b1, 1'b0, 1'b0);
    cur_tag = "R8"; expect_ovc(0, "R8 push-pull active-low normal high");
    cur_tag = "R4"; set_over(3'b010); adv(7999); expect_ovc(0, "R4 sel3 before");
    adv(1); expect_ovc(1, "R4 sel3 eight-second delay");
    set_idle(); adv(3);
    cur_tag = "R5"; test_req = 1'b1; adv(10); test_req = 1'b0; adv(1);
    test_req = 1'b1; adv(19); test_req = 1'b0;
    set_over(3'b010); adv(32); expect_ovc(0, "R5 broken request not latched");
    set_idle(); adv(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule